// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is a small processor built around a single 24-bit accumulator. Besides the accumulator it holds an index register, a link register, a program counter and a two-bit condition code. It talks to one byte-wide synchronous memory through a single port. Memory is byte addressed with 15-bit addresses. A 24-bit word takes three consecutive bytes, is named by its lowest address and stores its most significant byte first.

Every instruction is three bytes long. It is fetched one byte per cycle and then carried out in a few more cycles. The core handles loads and stores of the accumulator, index and link registers, addition and subtraction against memory, a signed compare that sets the condition code, conditional and unconditional jumps, and a subroutine call and return through the link register. Any undefined opcode halts the core for good. The register contents and a one-cycle retire strobe are brought out so that an enclosing system can follow execution.

Top module: `acc_cpu`

## Requirements
- R1: While reset is held and in the cycle after it is released, A, X and L read zero, the PC reads `RESET_PC` (default 0), the condition code reads 00, `halted` and `retire` are low, and the first byte read is requested from address `RESET_PC`.
- R2: An instruction is three bytes read from PC, PC+1 and PC+2 in that order. Byte 0 is the opcode. Bit 7 of byte 1 is the index flag. Bits 6..0 of byte 1 followed by byte 2 form the 15-bit address field. PC advances by 3, modulo 2^15, after every fetch.
- R3: The target address is the address field when the index flag is 0. When the flag is 1 it is the address field plus bits 14..0 of X, modulo 2^15.
- R4: LDA (00h), LDX (04h) and LDL (08h) load A, X or L with the word whose most significant byte is at the target address and whose other two bytes follow. No register changes in a cycle where `retire` is low.
- R5: STA (0Ch), STX (10h) and STL (14h) write the register's bytes, most significant first, to the target address, target+1 and target+2, and leave every register unchanged.
- R6: ADD (18h) and SUB (1Ch) replace A with A plus or minus the memory word, modulo 2^24.
- R7: COMP (28h) compares A with the memory word as signed two's complement values. It sets the condition code to 00 (less), 01 (equal) or 10 (greater) and leaves A unchanged. The code 11 never appears.
- R8: JEQ (30h), JGT (34h) and JLT (38h) load PC with the target address when the condition code is 01, 10 or 00 respectively, and otherwise fall through. J (3Ch) always jumps.
- R9: JSUB (48h) copies the address of the next instruction into L, zero-extended, and jumps to the target. RSUB (4Ch) loads PC from bits 14..0 of L.
- R10: Any other opcode raises `halted`, with PC already advanced past the bad instruction. From then on `halted` stays high, no write and no retire occur, and all registers hold.
- R11: `retire` pulses once in the last cycle of each instruction. Jumps and RSUB take 5 cycles, stores take 8, and loads, ADD, SUB and COMP take 10.
- R12: The memory port makes at most one byte access per cycle, never with read and write enables together. Read data is taken in the cycle after its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 15 | Byte address for the memory port |
| mem_re | output | 1 | Read request; data returns on `mem_rdata` next cycle |
| mem_we | output | 1 | Write enable for `mem_wdata` at `mem_addr` |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, one cycle after the request |
| retire | output | 1 | High in the last cycle of each completed instruction |
| halted | output | 1 | High once an undefined opcode has been met |
| dbg_a | output | 24 | Accumulator |
| dbg_x | output | 24 | Index register |
| dbg_l | output | 24 | Link register |
| dbg_pc | output | 24 | Program counter, zero-extended |
| dbg_cc | output | 2 | Condition code |

## Verification
The program mixes additions whose result wraps past 2^24, a compare against the most negative word, and taken and untaken branches whose wrong path lands on a halting byte. A core that compares unsigned, or mixes up the condition encodings, halts early or leaves PC different from the model. Indexed accesses use an X whose upper bits are set and whose sum with the address field overflows 15 bits. A core that does not wrap the sum, or uses all of X, reads or writes the wrong bytes. Returns go through an L value that LDL wrote, so a wrong byte order or a stale link shows up as a PC mismatch. Per-instruction cycle counts and the silence of the port after halting catch an extra or missing state and any write issued after the illegal opcode.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int WORD_W     = 24;
    localparam int BYTE_W     = 8;
    localparam int ADDR_W     = 15;
    localparam int WORD_BYTES = WORD_W / BYTE_W;
    localparam int CC_W       = 2;
    localparam int CNT_W      = $clog2(WORD_BYTES + 1);

    localparam logic [7:0] OPC_LDA  = 8'h00;
    localparam logic [7:0] OPC_LDX  = 8'h04;
    localparam logic [7:0] OPC_LDL  = 8'h08;
    localparam logic [7:0] OPC_STA  = 8'h0C;
    localparam logic [7:0] OPC_STX  = 8'h10;
    localparam logic [7:0] OPC_STL  = 8'h14;
    localparam logic [7:0] OPC_ADD  = 8'h18;
    localparam logic [7:0] OPC_SUB  = 8'h1C;
    localparam logic [7:0] OPC_COMP = 8'h28;
    localparam logic [7:0] OPC_JEQ  = 8'h30;
    localparam logic [7:0] OPC_JGT  = 8'h34;
    localparam logic [7:0] OPC_JLT  = 8'h38;
    localparam logic [7:0] OPC_J    = 8'h3C;
    localparam logic [7:0] OPC_JSUB = 8'h48;
    localparam logic [7:0] OPC_RSUB = 8'h4C;

    typedef enum logic [3:0] {
        OP_LDA, OP_LDX, OP_LDL, OP_STA, OP_STX, OP_STL,
        OP_ADD, OP_SUB, OP_COMP, OP_JEQ, OP_JGT, OP_JLT,
        OP_J, OP_JSUB, OP_RSUB, OP_BAD
    } op_e;

    typedef enum logic [CC_W-1:0] {
        CC_LT = 2'b00,
        CC_EQ = 2'b01,
        CC_GT = 2'b10
    } cc_e;

    typedef enum logic [2:0] {
        ST_FETCH, ST_DEC, ST_RD, ST_EX, ST_WR, ST_HALT
    } state_e;

    typedef struct packed {
        logic [7:0]        opc;
        logic              xflag;
        logic [ADDR_W-1:0] field;
    } instr_t;

    typedef struct packed {
        op_e  op;
        logic reads_mem;
        logic writes_mem;
        logic flow;
        logic bad;
    } dec_t;

    function automatic cc_e signed_cmp(input logic [WORD_W-1:0] lhs,
                                       input logic [WORD_W-1:0] rhs);
        if ($signed(lhs) < $signed(rhs))
            return CC_LT;
        else if (lhs == rhs)
            return CC_EQ;
        else
            return CC_GT;
    endfunction

endpackage

// File: rtl/acc_cpu_decoder.sv
module acc_cpu_decoder
    import acc_cpu_pkg::*;
(
    input  logic [7:0] opc,
    output dec_t       dec
);
    always_comb begin
        dec = '{op: OP_BAD, reads_mem: 1'b0, writes_mem: 1'b0, flow: 1'b0, bad: 1'b0};
        unique case (opc)
            OPC_LDA:  begin dec.op = OP_LDA;  dec.reads_mem = 1'b1; end
            OPC_LDX:  begin dec.op = OP_LDX;  dec.reads_mem = 1'b1; end
            OPC_LDL:  begin dec.op = OP_LDL;  dec.reads_mem = 1'b1; end
            OPC_ADD:  begin dec.op = OP_ADD;  dec.reads_mem = 1'b1; end
            OPC_SUB:  begin dec.op = OP_SUB;  dec.reads_mem = 1'b1; end
            OPC_COMP: begin dec.op = OP_COMP; dec.reads_mem = 1'b1; end
            OPC_STA:  begin dec.op = OP_STA;  dec.writes_mem = 1'b1; end
            OPC_STX:  begin dec.op = OP_STX;  dec.writes_mem = 1'b1; end
            OPC_STL:  begin dec.op = OP_STL;  dec.writes_mem = 1'b1; end
            OPC_JEQ:  begin dec.op = OP_JEQ;  dec.flow = 1'b1; end
            OPC_JGT:  begin dec.op = OP_JGT;  dec.flow = 1'b1; end
            OPC_JLT:  begin dec.op = OP_JLT;  dec.flow = 1'b1; end
            OPC_J:    begin dec.op = OP_J;    dec.flow = 1'b1; end
            OPC_JSUB: begin dec.op = OP_JSUB; dec.flow = 1'b1; end
            OPC_RSUB: begin dec.op = OP_RSUB; dec.flow = 1'b1; end
            default:  begin dec.op = OP_BAD;  dec.bad = 1'b1; end
        endcase
    end
endmodule

// File: rtl/acc_cpu_agen.sv
module acc_cpu_agen
    import acc_cpu_pkg::*;
(
    input  instr_t            ins,
    input  logic [WORD_W-1:0] xreg,
    output logic [ADDR_W-1:0] target
);
    logic [ADDR_W-1:0] offset;

    always_comb begin
        offset = ins.xflag ? xreg[ADDR_W-1:0] : '0;
        target = ins.field + offset;
    end
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
    import acc_cpu_pkg::*;
(
    input  op_e               op,
    input  logic [WORD_W-1:0] acc,
    input  logic [WORD_W-1:0] operand,
    output logic [WORD_W-1:0] result,
    output cc_e               cc
);
    always_comb begin
        result = (op == OP_SUB) ? acc - operand : acc + operand;
        cc     = signed_cmp(acc, operand);
    end
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              retire,
    output logic              halted,
    output logic [WORD_W-1:0] dbg_a,
    output logic [WORD_W-1:0] dbg_x,
    output logic [WORD_W-1:0] dbg_l,
    output logic [WORD_W-1:0] dbg_pc,
    output logic [CC_W-1:0]   dbg_cc
);
    localparam logic [CNT_W-1:0]  CNT_RD_LAST = CNT_W'(WORD_BYTES);
    localparam logic [CNT_W-1:0]  CNT_WR_LAST = CNT_W'(WORD_BYTES - 1);
    localparam logic [ADDR_W-1:0] PC_STEP     = ADDR_W'(WORD_BYTES);
    localparam int                PAD_W       = WORD_W - ADDR_W;

    state_e            state;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] pc;
    logic [WORD_W-1:0] acc, xr, lr;
    cc_e               cc;
    instr_t            ir;
    logic [WORD_W-1:0] rd_buf;
    logic [WORD_W-1:0] wr_buf;
    logic [ADDR_W-1:0] ta_q;

    dec_t              dec;
    logic [ADDR_W-1:0] ta;
    logic [WORD_W-1:0] alu_res;
    cc_e               alu_cc;
    logic              taken;
    logic [WORD_W-1:0] store_src;

    acc_cpu_decoder u_dec (
        .opc (ir.opc),
        .dec (dec)
    );

    acc_cpu_agen u_agen (
        .ins    (ir),
        .xreg   (xr),
        .target (ta)
    );

    acc_cpu_alu u_alu (
        .op      (dec.op),
        .acc     (acc),
        .operand (rd_buf),
        .result  (alu_res),
        .cc      (alu_cc)
    );

    always_comb begin
        unique case (dec.op)
            OP_JEQ:          taken = (cc == CC_EQ);
            OP_JGT:          taken = (cc == CC_GT);
            OP_JLT:          taken = (cc == CC_LT);
            OP_J, OP_JSUB:   taken = 1'b1;
            default:         taken = 1'b0;
        endcase
        unique case (dec.op)
            OP_STX:  store_src = xr;
            OP_STL:  store_src = lr;
            default: store_src = acc;
        endcase
    end

    // Memory port and retire strobe
    always_comb begin
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        retire    = 1'b0;
        mem_addr  = pc + ADDR_W'(cnt);
        mem_wdata = wr_buf[WORD_W-1 -: BYTE_W];
        unique case (state)
            ST_FETCH: mem_re = (cnt != CNT_RD_LAST);
            ST_DEC:   retire = dec.flow;
            ST_RD: begin
                mem_addr = ta_q + ADDR_W'(cnt);
                mem_re   = (cnt != CNT_RD_LAST);
            end
            ST_EX:    retire = 1'b1;
            ST_WR: begin
                mem_addr = ta_q + ADDR_W'(cnt);
                mem_we   = 1'b1;
                retire   = (cnt == CNT_WR_LAST);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_FETCH;
            cnt    <= '0;
            pc     <= RESET_PC;
            acc    <= '0;
            xr     <= '0;
            lr     <= '0;
            cc     <= CC_LT;
            ir     <= '0;
            rd_buf <= '0;
            wr_buf <= '0;
            ta_q   <= '0;
        end else begin
            unique case (state)
                ST_FETCH: begin
                    if (cnt != '0)
                        ir <= {ir[WORD_W-BYTE_W-1:0], mem_rdata};
                    if (cnt == CNT_RD_LAST) begin
                        cnt   <= '0;
                        pc    <= pc + PC_STEP;
                        state <= ST_DEC;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DEC: begin
                    ta_q <= ta;
                    if (dec.bad) begin
                        state <= ST_HALT;
                    end else if (dec.reads_mem) begin
                        state <= ST_RD;
                    end else if (dec.writes_mem) begin
                        wr_buf <= store_src;
                        state  <= ST_WR;
                    end else begin
                        if (dec.op == OP_RSUB)
                            pc <= lr[ADDR_W-1:0];
                        else if (taken)
                            pc <= ta;
                        if (dec.op == OP_JSUB)
                            lr <= {{PAD_W{1'b0}}, pc};
                        state <= ST_FETCH;
                    end
                end
                ST_RD: begin
                    if (cnt != '0)
                        rd_buf <= {rd_buf[WORD_W-BYTE_W-1:0], mem_rdata};
                    if (cnt == CNT_RD_LAST) begin
                        cnt   <= '0;
                        state <= ST_EX;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_EX: begin
                    unique case (dec.op)
                        OP_LDA:         acc <= rd_buf;
                        OP_LDX:         xr  <= rd_buf;
                        OP_LDL:         lr  <= rd_buf;
                        OP_ADD, OP_SUB: acc <= alu_res;
                        OP_COMP:        cc  <= alu_cc;
                        default: ;
                    endcase
                    state <= ST_FETCH;
                end
                ST_WR: begin
                    wr_buf <= wr_buf << BYTE_W;
                    if (cnt == CNT_WR_LAST) begin
                        cnt   <= '0;
                        state <= ST_FETCH;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_HALT;
            endcase
        end
    end

    assign halted = (state == ST_HALT);
    assign dbg_a  = acc;
    assign dbg_x  = xr;
    assign dbg_l  = lr;
    assign dbg_pc = {{PAD_W{1'b0}}, pc};
    assign dbg_cc = cc;

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
    import acc_cpu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              mem_re,
    input logic              mem_we,
    input logic              retire,
    input logic              halted,
    input logic [WORD_W-1:0] dbg_a,
    input logic [WORD_W-1:0] dbg_x,
    input logic [WORD_W-1:0] dbg_l,
    input logic [WORD_W-1:0] dbg_pc,
    input logic [CC_W-1:0]   dbg_cc
);
    assert_port_excl_R12: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));

    assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!mem_we && !retire));

    assert_halt_pc_hold_R10: assert property (@(posedge clk) disable iff (rst)
        halted |=> $stable(dbg_pc));

    assert_regs_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !retire |=> ($stable(dbg_a) && $stable(dbg_x) && $stable(dbg_l) && $stable(dbg_cc)));

    assert_cc_code_R7: assert property (@(posedge clk) disable iff (rst)
        dbg_cc != 2'b11);
endmodule

bind acc_cpu acc_cpu_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .mem_re (mem_re),
    .mem_we (mem_we),
    .retire (retire),
    .halted (halted),
    .dbg_a  (dbg_a),
    .dbg_x  (dbg_x),
    .dbg_l  (dbg_l),
    .dbg_pc (dbg_pc),
    .dbg_cc (dbg_cc)
);

// File: tb/acc_cpu_tb.sv
module acc_cpu_tb;
    localparam int MEM_BYTES = 4096;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [14:0] mem_addr;
    logic        mem_re, mem_we;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;
    logic        retire, halted;
    logic [23:0] dbg_a, dbg_x, dbg_l, dbg_pc;
    logic [1:0]  dbg_cc;

    always #5 clk = ~clk;

    acc_cpu u_dut (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .retire(retire), .halted(halted),
        .dbg_a(dbg_a), .dbg_x(dbg_x), .dbg_l(dbg_l), .dbg_pc(dbg_pc), .dbg_cc(dbg_cc)
    );

    logic [7:0] mem [MEM_BYTES];
    logic [7:0] mm  [MEM_BYTES];

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[11:0]];
    end

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [23:0] m_a = '0, m_x = '0, m_l = '0;
    logic [14:0] m_pc = '0;
    logic [1:0]  m_cc = 2'b00;
    bit          m_halt = 1'b0;
    bit          m_store = 1'b0;
    logic [14:0] m_ta = '0;
    int          m_cyc = 0;
    string       m_tag = "";

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic put_b(input int ad, input logic [7:0] v);
        mem[ad] <= v;
        mm[ad] = v;
    endtask

    task automatic put_i(input int ad, input logic [7:0] op, input bit x, input logic [14:0] f);
        put_b(ad, op);
        put_b(ad + 1, {x, f[14:8]});
        put_b(ad + 2, f[7:0]);
    endtask

    task automatic put_w(input int ad, input logic [23:0] w);
        put_b(ad, w[23:16]);
        put_b(ad + 1, w[15:8]);
        put_b(ad + 2, w[7:0]);
    endtask

    function automatic logic [23:0] m_word(input logic [14:0] ad);
        return {mm[ad[11:0]], mm[12'(ad[11:0] + 12'd1)], mm[12'(ad[11:0] + 12'd2)]};
    endfunction

    // Instruction-level reference model, stepped once per retired instruction
    task automatic model_step();
        logic [7:0]  op, b1, b2;
        logic [23:0] w, st;
        string xs;
        op = mm[m_pc[11:0]];
        b1 = mm[12'(m_pc[11:0] + 12'd1)];
        b2 = mm[12'(m_pc[11:0] + 12'd2)];
        m_pc = m_pc + 15'd3;                                       // R2
        m_ta = {b1[6:0], b2} + (b1[7] ? m_x[14:0] : 15'd0);        // R3
        xs = b1[7] ? " R3" : "";
        w = m_word(m_ta);
        m_store = 1'b0;
        st = m_a;
        m_cyc = 10;
        case (op)
            8'h00: begin m_a = w; m_tag = {"R4", xs}; end
            8'h04: begin m_x = w; m_tag = {"R4", xs}; end
            8'h08: begin m_l = w; m_tag = {"R4", xs}; end
            8'h0C, 8'h10, 8'h14: begin
                if (op == 8'h10) st = m_x;
                if (op == 8'h14) st = m_l;
                mm[m_ta[11:0]] = st[23:16];
                mm[12'(m_ta[11:0] + 12'd1)] = st[15:8];
                mm[12'(m_ta[11:0] + 12'd2)] = st[7:0];
                m_store = 1'b1; m_cyc = 8; m_tag = {"R5", xs};
            end
            8'h18: begin m_a = m_a + w; m_tag = {"R6", xs}; end
            8'h1C: begin m_a = m_a - w; m_tag = {"R6", xs}; end
            8'h28: begin
                if ($signed(m_a) < $signed(w)) m_cc = 2'b00;
                else if (m_a == w)             m_cc = 2'b01;
                else                           m_cc = 2'b10;
                m_tag = {"R7", xs};
            end
            8'h30, 8'h34, 8'h38, 8'h3C: begin
                if ((op == 8'h3C) || (op == 8'h30 && m_cc == 2'b01) ||
                    (op == 8'h34 && m_cc == 2'b10) || (op == 8'h38 && m_cc == 2'b00))
                    m_pc = m_ta;
                m_cyc = 5; m_tag = {"R8", xs};
            end
            8'h48: begin m_l = {9'd0, m_pc}; m_pc = m_ta; m_cyc = 5; m_tag = "R9"; end
            8'h4C: begin m_pc = m_l[14:0]; m_cyc = 5; m_tag = "R9"; end
            default: begin m_halt = 1'b1; m_tag = "R10"; end
        endcase
    endtask

    task automatic cmp_regs();
        chk({m_tag, " R2"}, "pc", {8'd0, dbg_pc}, {17'd0, m_pc});
        chk(m_tag, "A",  {8'd0, dbg_a}, {8'd0, m_a});
        chk(m_tag, "X",  {8'd0, dbg_x}, {8'd0, m_x});
        chk(m_tag, "L",  {8'd0, dbg_l}, {8'd0, m_l});
        chk(m_tag, "cc", {30'd0, dbg_cc}, {30'd0, m_cc});
        if (m_store) begin
            for (int i = 0; i < 3; i++)
                chk(m_tag, "stored byte", {24'd0, mem[12'(m_ta[11:0] + 12'(i))]},
                    {24'd0, mm[12'(m_ta[11:0] + 12'(i))]});
        end
    endtask

    // Program and reset checks
    initial begin
        for (int i = 0; i < MEM_BYTES; i++) put_b(i, 8'h00);
        put_w(12'h300, 24'h000005); put_w(12'h303, 24'hFFFFFE);
        put_w(12'h306, 24'h000010); put_w(12'h309, 24'h000003);
        put_w(12'h30C, 24'h800000); put_w(12'h326, 24'h00003C);
        put_w(12'h329, 24'h127FF0);
        put_i(12'h000, 8'h00, 0, 15'h300);  // LDA
        put_i(12'h003, 8'h18, 0, 15'h303);  // ADD wraps
        put_i(12'h006, 8'h1C, 0, 15'h306);  // SUB goes negative
        put_i(12'h009, 8'h04, 0, 15'h309);  // LDX 3
        put_i(12'h00C, 8'h00, 1, 15'h300);  // LDA indexed
        put_i(12'h00F, 8'h0C, 1, 15'h310);  // STA indexed
        put_i(12'h012, 8'h28, 0, 15'h306);  // COMP less
        put_i(12'h015, 8'h30, 0, 15'h01E);  // JEQ not taken
        put_i(12'h018, 8'h34, 0, 15'h01E);  // JGT not taken
        put_i(12'h01B, 8'h38, 0, 15'h021);  // JLT taken
        put_b(12'h01E, 8'hFF);
        put_i(12'h021, 8'h28, 0, 15'h303);  // COMP equal
        put_i(12'h024, 8'h38, 0, 15'h01E);  // JLT not taken
        put_i(12'h027, 8'h30, 0, 15'h02D);  // JEQ taken
        put_b(12'h02A, 8'hFF);
        put_i(12'h02D, 8'h48, 0, 15'h100);  // JSUB
        put_i(12'h030, 8'h14, 0, 15'h320);  // STL
        put_i(12'h033, 8'h10, 0, 15'h323);  // STX
        put_i(12'h036, 8'h08, 0, 15'h326);  // LDL
        put_i(12'h039, 8'h3C, 0, 15'h200);  // J
        put_i(12'h03C, 8'h28, 0, 15'h30C);  // COMP greater vs most negative
        put_i(12'h03F, 8'h34, 0, 15'h045);  // JGT taken
        put_b(12'h042, 8'hFF);
        put_i(12'h045, 8'h04, 0, 15'h329);  // LDX with upper bits set
        put_i(12'h048, 8'h00, 1, 15'h323);  // LDA indexed, sum wraps 15 bits
        put_i(12'h04B, 8'h3C, 1, 15'h061);  // J indexed, wraps
        put_b(12'h04E, 8'hFF);
        put_i(12'h051, 8'h28, 0, 15'h309);  // COMP less
        put_i(12'h054, 8'h34, 0, 15'h01E);  // JGT not taken
        put_i(12'h057, 8'h44, 0, 15'h000);  // undefined opcode
        put_i(12'h100, 8'h0C, 0, 15'h330);  // STA in subroutine
        put_i(12'h103, 8'h18, 0, 15'h303);  // ADD
        put_i(12'h106, 8'h4C, 0, 15'h000);  // RSUB
        put_i(12'h200, 8'h4C, 0, 15'h000);  // RSUB via loaded L

        repeat (3) @(negedge clk);
        chk("R1", "reset pc", {8'd0, dbg_pc}, 32'd0);
        chk("R1", "reset A", {8'd0, dbg_a}, 32'd0);
        chk("R1", "reset X", {8'd0, dbg_x}, 32'd0);
        chk("R1", "reset L", {8'd0, dbg_l}, 32'd0);
        chk("R1", "reset cc", {30'd0, dbg_cc}, 32'd0);
        chk("R1", "reset halted/retire", {30'd0, halted, retire}, 32'd0);
        chk("R1", "first fetch address", {16'd0, mem_re, mem_addr}, {16'd0, 1'b1, 15'd0});
        rst = 1'b0;
    end

    // Per-clock comparison against the model
    initial begin
        bit pend  = 1'b0;
        bit first = 1'b1;
        int cyc   = 0;
        int after = 0;
        wait (!rst);
        while (!done) begin
            @(negedge clk);
            cyc++;
            chk("R12", "read and write together", {31'd0, mem_re & mem_we}, 32'd0);
            if (pend) begin
                cmp_regs();
                pend = 1'b0;
            end
            if (retire) begin
                model_step();
                if (!first) chk({m_tag, " R11"}, "cycles per instruction", cyc, m_cyc);
                first = 1'b0;
                cyc = 0;
                pend = 1'b1;
            end
            if (halted && !m_halt) begin
                model_step();
                chk("R10", "model predicts halt", {31'd0, m_halt}, 32'd1);
                cmp_regs();
            end
            if (halted) begin
                chk("R10", "write or retire after halt", {30'd0, mem_we, retire}, 32'd0);
                chk("R10", "pc held after halt", {8'd0, dbg_pc}, {17'd0, m_pc});
                after++;
                if (after == 20) done = 1'b1;
            end
        end
        chk("R10", "halted still high", {31'd0, halted}, 32'd1);
        for (int i = 0; i < MEM_BYTES; i++)
            if (mem[i] !== mm[i]) chk("R5", "final memory", {24'd0, mem[i]}, {24'd0, mm[i]});
        checks++;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R10 watchdog expired actual=running expected=halted");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule